// File: doc/BRIEF.md
# Dual-Slot Store Commit Orderer

This block sequences the memory side effects of one execution packet. A packet may carry up to two scalar stores, one in slot 0 and one in slot 1, plus a load issued from slot 0. The block drives a single memory port with a valid/ready handshake and puts the accesses in the order the packet's semantics require. A slot-0 load must observe a live slot-1 store of the same packet, so that store is pushed to memory before the load reads. The block remembers the early write, so the store is not written a second time when the packet commits. At commit, any remaining slot-1 store goes out before the slot-0 store.

Each packet opens with a start strobe. The start strobe clears the per-slot cancel mask, which records stores whose predicate turned out false, and it also clears the early-write marker. Cancelled stores never reach memory. A packet that pairs a cache-line zeroing operation with any scalar store is flagged as an error and writes nothing. The store descriptors, the load address and size, and the zero-operation flag are held stable from packet start until the packet's done or error pulse.

Top module: `store_commit_orderer`

## Requirements
- R1: After reset, mem_req_o, done_o, err_o, ld_vld_o and s1_done_o are all low.
- R2: A load request is handled as follows. When slot 1 holds a valid store that is neither cancelled nor already written, that store is written first and then the load is read. Otherwise the load reads memory at once. ld_vld_o pulses for one cycle with the aligned load data, which is zero-extended.
- R3: s1_done_o rises after the slot-1 store is written and stays high until the next pkt_start_i. While it is high, a commit does not write slot 1 again.
- R4: A commit writes the slot-1 store and then the slot-0 store, and it writes each one only if it is valid, not cancelled and, for slot 1, not already written. done_o pulses for one cycle, starting on the cycle after the last write handshake. When there is nothing to write, done_o pulses on the cycle after the commit.
- R5: Setting bit k of cancel_set_i marks the slot-k store as cancelled for the current packet. A cancelled store is never written, either early or at commit.
- R6: pkt_start_i clears the cancel mask and the slot-1 written marker. A cancel_set_i applied in the same cycle is recorded for the new packet. A cancellation therefore never carries over into the next packet.
- R7: If a commit finds zero_op_i high while either store is valid, err_o pulses for one cycle and no write is issued. done_o does not pulse in that case.
- R8: While mem_req_o is high and mem_ready_i is low, the request stays asserted and its address, write enable, byte enables and write data stay unchanged.
- R9: Size code 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. The byte enables are the size mask shifted left by the low three address bits. Write data is shifted left by eight times that offset.
- R10: When ld_req_i and commit_i arrive in the same cycle, the load sequence runs first and the commit follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_start_i | input | 1 | Start of a new packet |
| cancel_set_i | input | 2 | Per-slot cancel bits, bit k = slot k |
| st_vld_i | input | 2 | Store present, bit k = slot k |
| st_addr_i | input | 2x ADDR_W | Store byte addresses per slot |
| st_size_i | input | 2x2 | Store size codes per slot |
| st_data_i | input | 2x DATA_W | Store data per slot, right-aligned |
| zero_op_i | input | 1 | Packet carries a cache-line zero operation |
| ld_req_i | input | 1 | Slot-0 load request strobe |
| ld_addr_i | input | ADDR_W | Load byte address |
| ld_size_i | input | 2 | Load size code |
| commit_i | input | 1 | Packet commit strobe |
| ld_vld_o | output | 1 | Load data valid pulse |
| ld_data_o | output | DATA_W | Aligned, zero-extended load data |
| s1_done_o | output | 1 | Slot-1 store already written this packet |
| done_o | output | 1 | Commit finished pulse |
| err_o | output | 1 | Zero-op/store conflict pulse |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_be_o | output | DATA_W/8 | Byte enables |
| mem_wdata_o | output | DATA_W | Write data, lane-aligned |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_rdata_i | input | DATA_W | Read data, valid on the read handshake |

## Verification
Several properties are checked by assertions on every cycle: the request stays stable under back-pressure, a load result only follows a read handshake, the slot-1 marker only rises after a write handshake and is cleared by packet start, a conflict error never overlaps a request, and the byte-enable patterns are legal. The order of writes relative to the read, the suppression of cancelled or already-written stores, and a cancel mask that does not carry over between packets all depend on whole packet sequences. Those are shown only by the bench's scenarios, which log every handshake and compare it with the expected order.

// File: rtl/sco_pkg.sv
package sco_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EARLY,
    ST_READ,
    ST_WR1,
    ST_WR0,
    ST_DONE,
    ST_ERR
  } seq_state_e;

  localparam int unsigned NUM_SLOTS = 2;
  localparam int unsigned SIZE_W    = 2;
endpackage

// File: rtl/sco_store_lane.sv
module sco_store_lane #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input  logic                   vld_i,
  input  logic                   cancel_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [1:0]             size_i,
  input  logic [DATA_W-1:0]      data_i,
  output logic                   live_o,
  output logic [DATA_W/8-1:0]    be_o,
  output logic [DATA_W-1:0]      wdata_o
);
  localparam int unsigned BYTES = DATA_W / 8;
  localparam int unsigned OFF_W = $clog2(BYTES);

  logic [OFF_W-1:0] off;
  logic [BYTES-1:0] raw_be;
  logic [3:0]       nbytes;

  assign off    = addr_i[OFF_W-1:0];
  assign nbytes = 4'd1 << size_i;
  assign live_o = vld_i & ~cancel_i;

  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      raw_be[b] = (4'(b) < nbytes);
    end
  end

  assign be_o    = raw_be << off;
  assign wdata_o = data_i << {off, 3'b000};
endmodule

// File: rtl/sco_load_align.sv
module sco_load_align #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [1:0]          size_i,
  input  logic [DATA_W-1:0]   rdata_i,
  output logic [DATA_W/8-1:0] be_o,
  output logic [DATA_W-1:0]   data_o
);
  localparam int unsigned BYTES = DATA_W / 8;
  localparam int unsigned OFF_W = $clog2(BYTES);

  logic [OFF_W-1:0]  off;
  logic [3:0]        nbytes;
  logic [BYTES-1:0]  raw_be;
  logic [DATA_W-1:0] keep;
  logic [DATA_W-1:0] shifted;

  assign off    = addr_i[OFF_W-1:0];
  assign nbytes = 4'd1 << size_i;

  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      raw_be[b]       = (4'(b) < nbytes);
      keep[b*8 +: 8]  = {8{raw_be[b]}};
    end
  end

  assign be_o    = raw_be << off;
  assign shifted = rdata_i >> {off, 3'b000};
  assign data_o  = shifted & keep;
endmodule

// File: rtl/sco_seq.sv
module sco_seq
  import sco_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pkt_start_i,
  input  logic [1:0] cancel_set_i,
  input  logic [1:0] vld_i,
  input  logic       zero_op_i,
  input  logic       ld_req_i,
  input  logic       commit_i,
  input  logic       mem_ready_i,
  output seq_state_e state_o,
  output logic [1:0] mask_o,
  output logic       s1_done_o,
  output logic       rd_fire_o
);
  seq_state_e state_q, state_d;
  logic [1:0] mask_q;
  logic       proc_q, proc_d;
  logic       pend_q, pend_d;
  logic       live0, live1, need1;

  assign live0 = vld_i[0] & ~mask_q[0];
  assign live1 = vld_i[1] & ~mask_q[1];
  assign need1 = live1 & ~proc_q;

  always_comb begin
    state_d = state_q;
    proc_d  = proc_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ld_req_i) begin
          state_d = need1 ? ST_EARLY : ST_READ;
          if (commit_i) pend_d = 1'b1;
        end else if (commit_i || pend_q) begin
          pend_d = 1'b0;
          if (zero_op_i && (vld_i != 2'b00)) state_d = ST_ERR;
          else if (need1)                    state_d = ST_WR1;
          else if (live0)                    state_d = ST_WR0;
          else                               state_d = ST_DONE;
        end
      end
      ST_EARLY: if (mem_ready_i) begin
        proc_d  = 1'b1;
        state_d = ST_READ;
      end
      ST_READ: if (mem_ready_i) state_d = ST_IDLE;
      ST_WR1: if (mem_ready_i) begin
        proc_d  = 1'b1;
        state_d = live0 ? ST_WR0 : ST_DONE;
      end
      ST_WR0: if (mem_ready_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      ST_ERR:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (pkt_start_i) proc_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= 2'b00;
      proc_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      proc_q  <= proc_d;
      pend_q  <= pend_d;
      mask_q  <= pkt_start_i ? cancel_set_i : (mask_q | cancel_set_i);
    end
  end

  assign state_o   = state_q;
  assign mask_o    = mask_q;
  assign s1_done_o = proc_q;
  assign rd_fire_o = (state_q == ST_READ) && mem_ready_i;
endmodule

// File: rtl/store_commit_orderer.sv
module store_commit_orderer
  import sco_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          pkt_start_i,
  input  logic [1:0]                    cancel_set_i,
  input  logic [1:0]                    st_vld_i,
  input  logic [1:0][ADDR_W-1:0]        st_addr_i,
  input  logic [1:0][1:0]               st_size_i,
  input  logic [1:0][DATA_W-1:0]        st_data_i,
  input  logic                          zero_op_i,
  input  logic                          ld_req_i,
  input  logic [ADDR_W-1:0]             ld_addr_i,
  input  logic [1:0]                    ld_size_i,
  input  logic                          commit_i,
  output logic                          ld_vld_o,
  output logic [DATA_W-1:0]             ld_data_o,
  output logic                          s1_done_o,
  output logic                          done_o,
  output logic                          err_o,
  output logic                          mem_req_o,
  output logic                          mem_we_o,
  output logic [ADDR_W-1:0]             mem_addr_o,
  output logic [DATA_W/8-1:0]           mem_be_o,
  output logic [DATA_W-1:0]             mem_wdata_o,
  input  logic                          mem_ready_i,
  input  logic [DATA_W-1:0]             mem_rdata_i
);
  localparam int unsigned BYTES = DATA_W / 8;

  seq_state_e                     state;
  logic [1:0]                     mask;
  logic                           rd_fire;
  logic [NUM_SLOTS-1:0]           lane_live;
  logic [NUM_SLOTS-1:0][BYTES-1:0]  lane_be;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] lane_wd;
  logic [BYTES-1:0]               ld_be;
  logic [DATA_W-1:0]              ld_aligned;
  logic                           ld_vld_q;
  logic [DATA_W-1:0]              ld_data_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_lane
    sco_store_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
      .vld_i    (st_vld_i[s]),
      .cancel_i (mask[s]),
      .addr_i   (st_addr_i[s]),
      .size_i   (st_size_i[s]),
      .data_i   (st_data_i[s]),
      .live_o   (lane_live[s]),
      .be_o     (lane_be[s]),
      .wdata_o  (lane_wd[s])
    );
  end

  sco_load_align #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ld (
    .addr_i  (ld_addr_i),
    .size_i  (ld_size_i),
    .rdata_i (mem_rdata_i),
    .be_o    (ld_be),
    .data_o  (ld_aligned)
  );

  sco_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pkt_start_i  (pkt_start_i),
    .cancel_set_i (cancel_set_i),
    .vld_i        (st_vld_i),
    .zero_op_i    (zero_op_i),
    .ld_req_i     (ld_req_i),
    .commit_i     (commit_i),
    .mem_ready_i  (mem_ready_i),
    .state_o      (state),
    .mask_o       (mask),
    .s1_done_o    (s1_done_o),
    .rd_fire_o    (rd_fire)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_be_o    = '0;
    mem_wdata_o = '0;
    unique case (state)
      ST_EARLY, ST_WR1: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = st_addr_i[1];
        mem_be_o    = lane_be[1];
        mem_wdata_o = lane_wd[1];
      end
      ST_WR0: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = st_addr_i[0];
        mem_be_o    = lane_be[0];
        mem_wdata_o = lane_wd[0];
      end
      ST_READ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ld_addr_i;
        mem_be_o   = ld_be;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_vld_q  <= 1'b0;
      ld_data_q <= '0;
    end else begin
      ld_vld_q <= rd_fire;
      if (rd_fire) ld_data_q <= ld_aligned;
    end
  end

  assign ld_vld_o  = ld_vld_q;
  assign ld_data_o = ld_data_q;
  assign done_o    = (state == ST_DONE);
  assign err_o     = (state == ST_ERR);

  logic unused_live;
  assign unused_live = ^lane_live;
endmodule

// File: rtl/sco_checker.sv
module sco_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   pkt_start_i,
  input logic                   ld_vld_o,
  input logic                   s1_done_o,
  input logic                   done_o,
  input logic                   err_o,
  input logic                   mem_req_o,
  input logic                   mem_we_o,
  input logic [ADDR_W-1:0]      mem_addr_o,
  input logic [DATA_W/8-1:0]    mem_be_o,
  input logic [DATA_W-1:0]      mem_wdata_o,
  input logic                   mem_ready_i
);
  // R8
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_we_o) &&
      $stable(mem_addr_o) && $stable(mem_be_o) && $stable(mem_wdata_o));

  // R2
  p_ld_after_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_vld_o |-> $past(mem_req_o && !mem_we_o && mem_ready_i));

  // R3
  p_s1_mark_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(s1_done_o) |-> $past(mem_req_o && mem_we_o && mem_ready_i));

  // R6
  p_start_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_i |=> !s1_done_o);

  // R7
  p_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mem_req_o && !done_o);

  // R4
  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  p_be_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
                   $countones(mem_be_o) == 4 || $countones(mem_be_o) == 8));
endmodule

bind store_commit_orderer sco_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_store_commit_orderer.sv
module tb_store_commit_orderer;
  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pkt_start_i = 1'b0;
  logic [1:0]       cancel_set_i = '0;
  logic [1:0]       st_vld_i = '0;
  logic [1:0][31:0] st_addr_i;
  logic [1:0][1:0]  st_size_i;
  logic [1:0][63:0] st_data_i;
  logic             zero_op_i = 1'b0;
  logic             ld_req_i = 1'b0;
  logic [31:0]      ld_addr_i = 32'h304;
  logic [1:0]       ld_size_i = 2'd2;
  logic             commit_i = 1'b0;
  logic             ld_vld_o;
  logic [63:0]      ld_data_o;
  logic             s1_done_o, done_o, err_o;
  logic             mem_req_o, mem_we_o;
  logic [31:0]      mem_addr_o;
  logic [7:0]       mem_be_o;
  logic [63:0]      mem_wdata_o;
  logic             mem_ready_i = 1'b1;
  logic [63:0]      mem_rdata_i;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  store_commit_orderer dut (.*);

  assign mem_rdata_i = {~mem_addr_o, mem_addr_o};

  // memory log
  int          log_n;
  logic [1:0]  log_op [8];
  logic [7:0]  log_be [8];
  logic [63:0] log_wd [8];
  always @(posedge clk_i) begin
    if (rst_ni && mem_req_o && mem_ready_i && log_n < 8) begin
      log_op[log_n] = !mem_we_o ? 2'd3 : (mem_addr_o == 32'h104 ? 2'd1 : 2'd2);
      log_be[log_n] = mem_be_o;
      log_wd[log_n] = mem_wdata_o;
      log_n++;
    end
  end

  logic       stall_en = 1'b0;
  logic [1:0] stall_cnt = '0;
  always @(negedge clk_i) begin
    stall_cnt   <= stall_cnt + 2'd1;
    mem_ready_i <= stall_en ? (stall_cnt == 2'd3) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // op codes: 1 = slot-1 write, 2 = slot-0 write, 3 = read; ops[1:0] first
  typedef struct packed {
    logic [1:0] vld;
    logic [1:0] cancel;
    logic       ld;
    logic       zero;
    logic       stall;
    logic [5:0] ops;
    logic       err;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'b11, 2'b11, 1'b1, 1'b0, 1'b0, 6'b00_00_11, 1'b0}, // R5 all cancelled
    '{2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 6'b00_10_01, 1'b0}, // R4 R6 both
    '{2'b01, 2'b00, 1'b0, 1'b0, 1'b1, 6'b00_00_10, 1'b0}, // R4 slot0 only
    '{2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 6'b00_00_01, 1'b0}, // R4 slot1 only
    '{2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 6'b00_00_00, 1'b0}, // R4 nothing
    '{2'b11, 2'b10, 1'b0, 1'b0, 1'b1, 6'b00_00_10, 1'b0}, // R5 slot1 cancelled
    '{2'b11, 2'b01, 1'b0, 1'b0, 1'b0, 6'b00_00_01, 1'b0}, // R5 slot0 cancelled
    '{2'b11, 2'b00, 1'b1, 1'b0, 1'b1, 6'b10_11_01, 1'b0}, // R2 R3 early
    '{2'b10, 2'b10, 1'b1, 1'b0, 1'b0, 6'b00_00_11, 1'b0}, // R2 R5 no early
    '{2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 6'b00_10_11, 1'b0}, // R2 read then s0
    '{2'b11, 2'b00, 1'b0, 1'b1, 1'b0, 6'b00_00_00, 1'b1}, // R7 conflict
    '{2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 6'b00_00_11, 1'b0}  // R7 zero-op alone
  };

  function automatic logic [63:0] exp_ld(input logic [31:0] a, input logic [1:0] sz);
    logic [63:0] r;
    r = {~a, a} >> (8 * a[2:0]);
    case (sz)
      2'd0: r &= 64'hFF;
      2'd1: r &= 64'hFFFF;
      2'd2: r &= 64'hFFFF_FFFF;
      default: ;
    endcase
    return r;
  endfunction

  task automatic run_pkt(input vec_t v, input bit same, input bit restart, input string tag);
    int n_exp;
    bit got;
    bit s1w;
    stall_en = v.stall;
    if (restart) begin
      @(negedge clk_i);
      pkt_start_i  = 1'b1;
      cancel_set_i = v.cancel;
      st_vld_i     = v.vld;
      zero_op_i    = v.zero;
      @(negedge clk_i);
      pkt_start_i  = 1'b0;
      cancel_set_i = 2'b00;
      chk(s1_done_o == 1'b0, {tag, " R6 marker cleared"}, 64'(s1_done_o), 64'd0);
    end else begin
      @(negedge clk_i);
    end
    log_n = 0;
    if (v.ld) begin
      ld_req_i = 1'b1;
      if (same) commit_i = 1'b1;
      @(negedge clk_i);
      ld_req_i = 1'b0;
      commit_i = 1'b0;
      got = 0;
      for (int k = 0; k < 200; k++) begin
        if (ld_vld_o) begin got = 1; break; end
        @(negedge clk_i);
      end
      chk(got, {tag, " R2 load returned"}, 64'(got), 64'd1);
      chk(ld_data_o == exp_ld(ld_addr_i, ld_size_i), {tag, " R2 load data"},
          ld_data_o, exp_ld(ld_addr_i, ld_size_i));
    end
    if (!same) begin
      commit_i = 1'b1;
      @(negedge clk_i);
      commit_i = 1'b0;
    end
    for (int k = 0; k < 200; k++) begin
      if (done_o || err_o) break;
      @(negedge clk_i);
    end
    chk(err_o == v.err, {tag, " R7 error flag"}, 64'(err_o), 64'(v.err));
    chk(done_o == !v.err, {tag, " R4 done pulse"}, 64'(done_o), 64'(!v.err));
    @(negedge clk_i);
    chk(!done_o && !err_o, {tag, " R4 single pulse"}, 64'({done_o, err_o}), 64'd0);
    n_exp = 0;
    s1w = 0;
    for (int i = 0; i < 3; i++) begin
      if (v.ops[2*i +: 2] != 2'd0) n_exp++;
      if (v.ops[2*i +: 2] == 2'd1) s1w = 1;
    end
    chk(log_n == n_exp, {tag, " R4 access count"}, 64'(log_n), 64'(n_exp));
    for (int i = 0; i < 3; i++) begin
      if (i < n_exp && i < log_n)
        chk(log_op[i] == v.ops[2*i +: 2], {tag, " R4 access order"},
            64'(log_op[i]), 64'(v.ops[2*i +: 2]));
    end
    if (restart)
      chk(s1_done_o == s1w, {tag, " R3 slot1 marker"}, 64'(s1_done_o), 64'(s1w));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    st_addr_i[1] = 32'h104; st_size_i[1] = 2'd2; st_data_i[1] = 64'h1111_2222_3333_4444;
    st_addr_i[0] = 32'h203; st_size_i[0] = 2'd0; st_data_i[0] = 64'hAAAA_BBBB_CCCC_DDDD;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!mem_req_o && !done_o && !err_o && !ld_vld_o && !s1_done_o, "R1 reset outputs",
        64'({mem_req_o, done_o, err_o, ld_vld_o, s1_done_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!mem_req_o, "R1 idle after reset", 64'(mem_req_o), 64'd0);

    foreach (VECS[i]) begin
      run_pkt(VECS[i], 1'b0, 1'b1, $sformatf("vec%0d", i));
      if (i == 1) begin
        // R9 byte lanes: slot1 4B at off 4, slot0 1B at off 3
        chk(log_be[0] == 8'hF0, "R9 slot1 be", 64'(log_be[0]), 64'hF0);
        chk(log_wd[0] == 64'h3333_4444_0000_0000, "R9 slot1 data", log_wd[0], 64'h3333_4444_0000_0000);
        chk(log_be[1] == 8'h08, "R9 slot0 be", 64'(log_be[1]), 64'h08);
        chk(log_wd[1] == 64'hBBCC_CCDD_DD00_0000, "R9 slot0 data", log_wd[1], 64'hBBCC_CCDD_DD00_0000);
      end
    end

    // R3: second commit after early write only rewrites slot 0
    run_pkt('{2'b11, 2'b00, 1'b1, 1'b0, 1'b0, 6'b10_11_01, 1'b0}, 1'b0, 1'b1, "r3_a");
    run_pkt('{2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 6'b00_00_10, 1'b0}, 1'b0, 1'b0, "r3_b");
    chk(s1_done_o == 1'b1, "R3 marker held", 64'(s1_done_o), 64'd1);

    // R10: load and commit in the same cycle, with a 1-byte load at offset 5
    ld_addr_i = 32'h305; ld_size_i = 2'd0;
    run_pkt('{2'b11, 2'b00, 1'b1, 1'b0, 1'b1, 6'b10_11_01, 1'b0}, 1'b1, 1'b1, "r10_same");
    ld_addr_i = 32'h300; ld_size_i = 2'd3;
    run_pkt('{2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 6'b00_10_11, 1'b0}, 1'b1, 1'b1, "r10_dw");

    // R6: cancel applied with start, then a fresh packet is not cancelled
    run_pkt('{2'b11, 2'b11, 1'b0, 1'b0, 1'b0, 6'b00_00_00, 1'b0}, 1'b0, 1'b1, "r6_a");
    run_pkt('{2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 6'b00_10_01, 1'b0}, 1'b0, 1'b1, "r6_b");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule